// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer Unit

This block is the top level of a group of down-counting timers that share one clock divider. A 16-bit prescaler counts down once per clock. When it passes zero it reloads from its own reload register and raises a tick for one cycle. Every channel counts on that tick. The prescaler therefore sets the time base for all channels at once, and each channel sets its own period in tick units.

Software reaches the block through a word-addressed register port. The port has an address, a write strobe, write data and combinational read data. The lowest 16-byte window holds the prescaler registers and a read-only capability word. That word reports how many channels are built, the first interrupt line they use and two fixed feature flags. Each channel owns the next 16-byte window in turn. Each channel drives its own interrupt output, which pulses for one cycle when the channel passes zero.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the prescaler value register (0x00), the prescaler reload register (0x04) and every register of every channel read as 0, and all interrupt outputs are low.
- R2: The prescaler value and prescaler reload registers are 16 bits wide. A write keeps write data bits [15:0], and bits [31:16] always read back as 0.
- R3: The prescaler value decreases by one each clock. In the clock after it is 0, it is loaded from the prescaler reload register and `tick` is high for that one cycle. With reload R, `tick` is high once every R+1 clocks. With R = 0, `tick` is high on every clock.
- R4: The capability word at 0x08 is read-only and writes to it have no effect. Its fields are:
  - bits [2:0]: the channel count modulo 8;
  - bits [7:3]: the base interrupt line number (default 8);
  - bit 8: 1;
  - bit 9: 1;
  - all other bits: 0.
  
  With the default two channels it reads 0x342.
- R5: Channel n (counting from 0) owns the window starting at 0x10*(n+1). Within the window, +0x0 is the counter, +0x4 is the reload value and +0x8 is the control register.
- R6: Reads of any unmapped offset return 0, and writes to such an offset change no register. This covers offset 0x0C of any window, and any window above the last channel present.
- R7: Only address bits [7:0] are decoded, so any higher address bits are ignored.
- R8: A read of a channel's counter offset returns its live count. A write to that offset sets the count directly.
- R9: The channel control register has these bits:
  - bit 0: enable.
  - bit 1: auto-restart.
  - bit 2: load. Writing 1 copies the reload value into the counter, and the bit always reads 0.
  - bit 3: interrupt enable.
  - bit 4: pending. Writing 1 clears it and writing 0 leaves it unchanged.
  
  The bits above bit 4 read 0.
- R10: On each tick, an enabled channel counts down by one. On a tick when its count is already 0, the channel instead does three things:
  - If interrupt enable is set, it sets pending and pulses its own interrupt output for one cycle. Pending set wins over a clear in the same cycle.
  - If auto-restart is set, it reloads the counter.
  - If auto-restart is clear, it clears enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register port; only bits [7:0] are decoded |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tick | output | 1 | One-cycle prescaler tick shared by all channels |
| irq | output | N_CH | One-cycle interrupt pulse per channel |

## Verification
The bench measures the distance between ticks for a reload of 0, 1, 4 and a random value, with one expected value for each. A prescaler that reloaded one clock late, or counted to reload instead of reload+1, would miss these distances by one. It probes the unmapped slot 0x0C, the first absent channel window and addresses with high bits set. A decoder that aliased slots or kept upper address bits would either return data there or let a write there change a live register. It also covers:
- the count read while running, with an exact expected value;
- the pending bit kept by a write of 0 and cleared by a write of 1;
- a one-shot channel dropping its enable at underflow;
- the load bit reading 0.

A channel with its logic off by one cycle, or one that failed to clear enable, would fail the readback of its count or its control bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W    = 32;
    localparam int SCALE_W  = 16;
    localparam int DEC_W    = 8;

    typedef enum logic [1:0] {
        FLD_CNT  = 2'd0,
        FLD_RLD  = 2'd1,
        FLD_CTL  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_RST  = 1;
    localparam int CTL_LOAD = 2;
    localparam int CTL_IE   = 3;
    localparam int CTL_PEND = 4;

    localparam int CAP_SEP_IRQ   = 8;
    localparam int CAP_NO_FREEZE = 9;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_val_i,
    input  logic               wr_rld_i,
    input  logic [SCALE_W-1:0] wdata_i,
    output logic [SCALE_W-1:0] value_o,
    output logic [SCALE_W-1:0] reload_o,
    output logic               tick_o
);

    typedef struct packed {
        logic [SCALE_W-1:0] value;
        logic [SCALE_W-1:0] reload;
        logic               tick;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.value == '0) begin
            st_d.value = st_q.reload;
            st_d.tick  = 1'b1;
        end else begin
            st_d.value = st_q.value - 1'b1;
            st_d.tick  = 1'b0;
        end
        if (wr_val_i) st_d.value  = wdata_i;
        if (wr_rld_i) st_d.reload = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_o  = st_q.value;
    assign reload_o = st_q.reload;
    assign tick_o   = st_q.tick;

    // R3: reaching zero produces a tick and a reload in the next cycle
    assert_tick_on_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.value == '0 && !wr_val_i) |=> (st_q.tick && st_q.value == $past(st_q.reload)));

    // R3: a nonzero value steps down by one without a tick
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.value != '0 && !wr_val_i) |=> (!st_q.tick && st_q.value == $past(st_q.value) - 16'd1));

endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic [DEC_W-1:0] off_i,
    output logic             unit_sel_o,
    output logic [N_CH-1:0]  ch_sel_o,
    output fld_e             fld_o
);

    logic [3:0] slot;
    fld_e       fld;

    assign slot  = off_i[7:4];
    assign fld   = fld_e'(off_i[3:2]);
    assign fld_o = fld;

    assign unit_sel_o = (slot == 4'd0) && (fld != FLD_NONE);

    for (genvar k = 0; k < N_CH; k++) begin : g_sel
        assign ch_sel_o[k] = (slot == 4'(k + 1)) && (fld != FLD_NONE);
    end

    // R5: an address selects at most one register window
    always_comb begin
        assert_one_window_R5: assert ($onehot0({unit_sel_o, ch_sel_o}));
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sel_i,
    input  logic             we_i,
    input  fld_e             fld_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             en;
        logic             rst;
        logic             ie;
        logic             pend;
        logic             irq;
    } ch_t;

    ch_t  st_d, st_q;
    logic we_cnt, we_rld, we_ctl, hit_zero;

    assign we_cnt   = sel_i && we_i && (fld_i == FLD_CNT);
    assign we_rld   = sel_i && we_i && (fld_i == FLD_RLD);
    assign we_ctl   = sel_i && we_i && (fld_i == FLD_CTL);
    assign hit_zero = tick_i && st_q.en && (st_q.cnt == '0);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (tick_i && st_q.en) begin
            if (st_q.cnt == '0) begin
                if (st_q.rst) st_d.cnt = st_q.rld;
                else          st_d.en  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (we_cnt) st_d.cnt = wdata_i[CNT_W-1:0];
        if (we_rld) st_d.rld = wdata_i[CNT_W-1:0];
        if (we_ctl) begin
            st_d.en  = wdata_i[CTL_EN];
            st_d.rst = wdata_i[CTL_RST];
            st_d.ie  = wdata_i[CTL_IE];
            if (wdata_i[CTL_PEND]) st_d.pend = 1'b0;
            if (wdata_i[CTL_LOAD]) st_d.cnt  = st_q.rld;
        end
        if (hit_zero && st_q.ie) begin
            st_d.pend = 1'b1;
            st_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (fld_i)
            FLD_CNT: rdata_o = REG_W'(st_q.cnt);
            FLD_RLD: rdata_o = REG_W'(st_q.rld);
            FLD_CTL: begin
                rdata_o[CTL_EN]   = st_q.en;
                rdata_o[CTL_RST]  = st_q.rst;
                rdata_o[CTL_IE]   = st_q.ie;
                rdata_o[CTL_PEND] = st_q.pend;
            end
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    // R10: an interrupt pulse always leaves the pending flag set
    assert_irq_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.pend);

    // R10: an enabled channel steps down by one on a tick
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.en && st_q.cnt != '0 && !(sel_i && we_i)) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    // R10: a one-shot underflow drops enable
    assert_oneshot_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_zero && !st_q.rst && !(sel_i && we_i)) |=> !st_q.en);

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int N_CH     = 2,
    parameter int IRQ_BASE = 8,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              tick,
    output logic [N_CH-1:0]   irq
);

    localparam logic [REG_W-1:0] CAP_WORD =
        REG_W'(N_CH % 8) |
        (REG_W'(IRQ_BASE & 31) << 3) |
        (REG_W'(1) << CAP_SEP_IRQ) |
        (REG_W'(1) << CAP_NO_FREEZE);

    logic                unit_sel;
    logic [N_CH-1:0]     ch_sel;
    fld_e                fld;
    logic [SCALE_W-1:0]  pre_value, pre_reload;
    logic [REG_W-1:0]    ch_rd [N_CH];

    tmr_decode #(.N_CH(N_CH)) u_decode (
        .off_i      (reg_addr[DEC_W-1:0]),
        .unit_sel_o (unit_sel),
        .ch_sel_o   (ch_sel),
        .fld_o      (fld)
    );

    tmr_prescaler u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_val_i (unit_sel && reg_we && fld == FLD_CNT),
        .wr_rld_i (unit_sel && reg_we && fld == FLD_RLD),
        .wdata_i  (reg_wdata[SCALE_W-1:0]),
        .value_o  (pre_value),
        .reload_o (pre_reload),
        .tick_o   (tick)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_channel (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .sel_i   (ch_sel[k]),
            .we_i    (reg_we),
            .fld_i   (fld),
            .wdata_i (reg_wdata),
            .rdata_o (ch_rd[k]),
            .irq_o   (irq[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (unit_sel) begin
            unique case (fld)
                FLD_CNT: reg_rdata = REG_W'(pre_value);
                FLD_RLD: reg_rdata = REG_W'(pre_reload);
                FLD_CTL: reg_rdata = CAP_WORD;
                default: reg_rdata = '0;
            endcase
        end
        for (int k = 0; k < N_CH; k++) begin
            if (ch_sel[k]) reg_rdata = reg_rdata | ch_rd[k];
        end
    end

    // R6: an offset that selects no register reads as zero
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(unit_sel || (|ch_sel)) |-> reg_rdata == '0);

    // R1: interrupts stay low in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> irq == '0);

endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;

    localparam int N_CH = 2;
    localparam int ADDR_W = 12;
    localparam logic [31:0] CAP = 32'h342;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              tick;
    logic [N_CH-1:0]   irq;

    int n_checks = 0;
    int n_fail = 0;

    tmr_unit #(.N_CH(N_CH), .IRQ_BASE(8), .ADDR_W(ADDR_W), .CNT_W(32)) u_tmr_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_check(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    function automatic logic [31:0] scale_model(logic [31:0] d);
        return {16'h0, d[15:0]};
    endfunction

    task automatic measure_period(int r);
        int gap;
        wr(12'h004, 32'(r));
        wr(12'h000, 32'h0);
        repeat (3) @(negedge clk);
        while (tick !== 1'b1) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (tick !== 1'b1 && gap < 100);
        check("R3 tick period", 32'(gap), 32'(r + 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] model [4];
        logic [ADDR_W-1:0] tgt [4];
        int i0, i1;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 scaler value", 12'h000, 0);
        rd_check("R1 scaler reload", 12'h004, 0);
        for (int k = 0; k < N_CH; k++) begin
            rd_check("R1 ch counter", 12'(16 * (k + 1)), 0);
            rd_check("R1 ch reload", 12'(16 * (k + 1) + 4), 0);
            rd_check("R1 ch control", 12'(16 * (k + 1) + 8), 0);
        end
        check("R1 irq low", 32'(irq), 0);

        // R4 capability word
        rd_check("R4 capability", 12'h008, CAP);
        wr(12'h008, 32'hFFFF_FFFF);
        rd_check("R4 capability after write", 12'h008, CAP);

        // R2 width masking
        wr(12'h004, 32'hABCD_1234);
        rd_check("R2 reload mask", 12'h004, 32'h0000_1234);
        wr(12'h000, 32'h5A5A_0003);
        rd(12'h000, v);
        check("R2 value mask upper", {16'h0, v[31:16]}, 0);

        // R3 tick rate
        wr(12'h004, 32'h0);
        wr(12'h000, 32'h0);
        repeat (2) @(negedge clk);
        i0 = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (tick === 1'b1) i0++;
        end
        check("R3 tick every clock at reload 0", 32'(i0), 4);
        measure_period(1);
        measure_period(4);
        measure_period(2 + int'($urandom_range(18)));
        @(negedge clk);
        check("R3 tick one cycle wide", 32'(tick), 0);

        // R7 upper address bits ignored
        wr(12'h104, 32'h0000_0007);
        rd_check("R7 alias write", 12'h004, 7);
        rd_check("R7 alias read", 12'hF08, CAP);

        // back to a tick every clock
        wr(12'h004, 32'h0);
        wr(12'h000, 32'h0);

        // R5 window map
        wr(12'h014, 32'hCAFE_0001);
        wr(12'h024, 32'h1234_5678);
        rd_check("R5 ch0 reload", 12'h014, 32'hCAFE_0001);
        rd_check("R5 ch1 reload", 12'h024, 32'h1234_5678);
        wr(12'h020, 32'h0000_0042);
        rd_check("R5 ch1 counter", 12'h020, 32'h42);
        rd_check("R5 ch0 counter untouched", 12'h010, 0);

        // R6 unmapped
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h034, 32'hDEAD_BEEF);
        wr(12'h00C, 32'hDEAD_BEEF);
        wr(12'h01C, 32'hDEAD_BEEF);
        rd_check("R6 unit 0x0C", 12'h00C, 0);
        rd_check("R6 ch 0x1C", 12'h01C, 0);
        rd_check("R6 absent ch 0x30", 12'h030, 0);
        rd_check("R6 absent ch 0x34", 12'h034, 0);
        rd_check("R6 high slot 0xF4", 12'h0F4, 0);
        rd_check("R6 ch0 reload kept", 12'h014, 32'hCAFE_0001);
        rd_check("R6 scaler reload kept", 12'h004, 0);

        // R8 live count
        wr(12'h010, 32'd100);
        rd_check("R8 counter write", 12'h010, 100);
        wr(12'h018, 32'h1);
        reg_addr = 12'h010;
        repeat (5) @(negedge clk);
        #1 check("R8 live count", reg_rdata, 95);
        wr(12'h018, 32'h0);

        // R9 load bit
        wr(12'h014, 32'd5);
        wr(12'h018, 32'h4);
        rd_check("R9 load copies reload", 12'h010, 5);
        rd_check("R9 load reads zero", 12'h018, 0);

        // R10 periodic with interrupt
        wr(12'h010, 32'd3);
        wr(12'h018, 32'hB);
        i0 = 0; i1 = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (irq[0] === 1'b1) i0++;
            if (irq[1] === 1'b1) i1++;
        end
        check("R10 ch0 irq pulses", 32'(i0), 3);
        check("R10 ch1 irq silent", 32'(i1), 0);
        rd(12'h018, v);
        check("R10 restart keeps enable, pending set", v, 32'h1B);

        // R9 pending write semantics
        wr(12'h018, 32'h0);
        rd_check("R9 write 0 keeps pending", 12'h018, 32'h10);
        wr(12'h018, 32'h10);
        rd_check("R9 write 1 clears pending", 12'h018, 0);

        // R10 one-shot
        wr(12'h010, 32'd2);
        wr(12'h018, 32'h9);
        i0 = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (irq[0] === 1'b1) i0++;
        end
        check("R10 one-shot single pulse", 32'(i0), 1);
        rd_check("R10 one-shot drops enable", 12'h018, 32'h18);
        rd_check("R10 one-shot count holds at 0", 12'h010, 0);

        // random register traffic against a model
        tgt[0] = 12'h004; tgt[1] = 12'h014; tgt[2] = 12'h024; tgt[3] = 12'h034;
        model[0] = 0; model[1] = 5; model[2] = 32'h1234_5678; model[3] = 0;
        for (int n = 0; n < 40; n++) begin
            int t, s;
            logic [31:0] d;
            t = int'($urandom_range(3));
            d = $urandom();
            wr(tgt[t] | (12'($urandom_range(15)) << 8), d);
            if (t == 0) model[0] = scale_model(d);
            else if (t != 3) model[t] = d;
            s = int'($urandom_range(3));
            if (s == 0) rd_check("R2 random scaler reload", tgt[s], model[s]);
            else if (s == 3) rd_check("R6 random absent", tgt[s], model[s]);
            else rd_check("R5 random ch reload", tgt[s], model[s]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule